// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on unrelated clocks. The writer pushes words with an active-low write enable, and the reader pops them with a pair of active-low read enables. Four active-low status flags report the fill level. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The two almost-thresholds are offsets driven in by a companion register block, and the flags follow them on every edge of the owning clock.

Each side keeps a binary pointer one bit wider than the address. The pointer is published as a registered Gray code and brought into the other domain through two flops. The word count for each flag is formed in the domain that owns the flag. The second write-enable pin has two roles. While reset is held, its level chooses between a two-enable write mode and a programmable mode in which the first enable alone controls writes. That choice then holds until the next reset.

Back-pressure on the write port is the full flag. A write attempted while full is dropped rather than held, so the writer must watch the flag and repeat the word. On the read port the empty flag plays the same role. Data appears on the output register at the read edge and stays there until the next accepted read.

Top module: `fifo9_dc`

## Requirements
- R1: While reset is asserted and after it is released, with no traffic, empty_n is 0, full_n is 1, almost_empty_n is 0, almost_full_n is 1 (full offset below DEPTH), and rd_data is 0.
- R2: The level of wr_en2_cfg is captured while reset is asserted: 1 selects two-enable mode and 0 selects programmable mode. Changes on the pin after reset do not change the mode.
- R3: In two-enable mode a word is stored only when wr_en1_n is 0, wr_en2_cfg is 1 and the FIFO is not full. Every other enable combination stores nothing.
- R4: In programmable mode a word is stored whenever wr_en1_n is 0 and the FIFO is not full, at either level of wr_en2_cfg.
- R5: A write attempted while full_n is 0 is dropped, and the stored contents are unchanged.
- R6: A read takes place only when rd_en1_n and rd_en2_n are both 0 and the FIFO is not empty. Words leave in the order they were written.
- R7: A read attempted while empty_n is 0 is ignored, and rd_data keeps the last word read.
- R8: Once the pointers settle, empty_n is 0 exactly when 0 words are held, and almost_empty_n is 0 exactly when the count is at most ae_offset (N). Both change only on rclk edges.
- R9: Once the pointers settle, full_n is 0 exactly when DEPTH words are held, and almost_full_n is 0 exactly when the count is at least DEPTH minus af_offset (M). Both change only on wclk edges.
- R10: A word written into an empty FIFO does not reach rd_data on its own. It appears at the first read accepted after empty_n goes to 1.
- R11: Each pointer crosses to the other domain as a Gray code that changes by at most one bit per clock of its own domain. The word count held by either side never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released per domain |
| wr_data | input | 9 | Word to store |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_cfg | input | 1 | Mode select during reset; active-high second write enable in two-enable mode |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| ae_offset | input | log2(DEPTH)+1 | Almost-empty offset N |
| af_offset | input | log2(DEPTH)+1 | Almost-full offset M |
| rd_data | output | 9 | Output register holding the last word read |
| empty_n | output | 1 | Low when empty (rclk domain) |
| almost_empty_n | output | 1 | Low when N or fewer words are held (rclk domain) |
| full_n | output | 1 | Low when full (wclk domain) |
| almost_full_n | output | 1 | Low when DEPTH-M or more words are held (wclk domain) |

## Verification
Four offset pairs are swept, each with a full fill one word at a time followed by a full drain. After every step all four flags are compared with the count held by a queue model, so each threshold is crossed in both directions at several positions. The fill and drain each go one step past the limit. These extra steps separate a correctly dropped write or read from one that wraps a pointer or corrupts data. Separate patterns drive every write and read enable combination in both modes and change the mode pin after reset. They also poll the empty flag after a single write, which tells a correct mode latch and enable decode apart from an early or spontaneous output update.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  typedef enum logic {
    WMODE_DUAL_EN = 1'b0,
    WMODE_PROG    = 1'b1
  } wmode_e;
endpackage

// File: rtl/fifo9_rst_sync.sv
module fifo9_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n,
  output logic cfg_win
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign srst_n  = q2;
  assign cfg_win = ~q1;
endmodule

// File: rtl/fifo9_ptr_sync.sv
module fifo9_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_out[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/fifo9_wr_ctl.sv
module fifo9_wr_ctl
  import fifo9_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_win,
  input  logic          en1_n,
  input  logic          en2_cfg,
  input  logic [AW:0]   rptr_s,
  input  logic [AW:0]   af_ofs,
  output logic          fire,
  output logic [AW-1:0] addr,
  output logic [AW:0]   gray,
  output logic          full_n,
  output logic          af_n
);
  localparam int CW = AW + 1;
  localparam logic [CW:0] DEPTH_X = (CW+1)'(1 << AW);

  wmode_e      mode_q;
  logic [AW:0] bin_q, bin_nx, cnt_nx;
  logic        req;

  always_ff @(posedge clk) begin
    if (cfg_win) mode_q <= en2_cfg ? WMODE_DUAL_EN : WMODE_PROG;
  end

  always_comb begin
    if (mode_q == WMODE_PROG) req = !en1_n;
    else                      req = !en1_n && en2_cfg;
  end

  assign fire   = req && full_n;
  assign bin_nx = bin_q + {{AW{1'b0}}, fire};
  assign cnt_nx = bin_nx - rptr_s;
  assign addr   = bin_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray   <= '0;
      full_n <= 1'b1;
      af_n   <= 1'b1;
    end else begin
      bin_q  <= bin_nx;
      gray   <= bin_nx ^ (bin_nx >> 1);
      full_n <= ({1'b0, cnt_nx} != DEPTH_X);
      af_n   <= (({1'b0, cnt_nx} + {1'b0, af_ofs}) < DEPTH_X);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n) |=> (bin_q == $past(bin_q))); // R5
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1); // R11
  AST_WCOUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, bin_q - rptr_s} <= DEPTH_X)); // R11
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q)); // R2
endmodule

// File: rtl/fifo9_rd_ctl.sv
module fifo9_rd_ctl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en1_n,
  input  logic          en2_n,
  input  logic [AW:0]   wptr_s,
  input  logic [AW:0]   ae_ofs,
  output logic          fire,
  output logic [AW-1:0] addr,
  output logic [AW:0]   gray,
  output logic          empty_n,
  output logic          ae_n
);
  localparam int CW = AW + 1;
  localparam logic [CW:0] DEPTH_X = (CW+1)'(1 << AW);

  logic [AW:0] bin_q, bin_nx, cnt_nx;

  assign fire   = !en1_n && !en2_n && empty_n;
  assign bin_nx = bin_q + {{AW{1'b0}}, fire};
  assign cnt_nx = wptr_s - bin_nx;
  assign addr   = bin_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      gray    <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
    end else begin
      bin_q   <= bin_nx;
      gray    <= bin_nx ^ (bin_nx >> 1);
      empty_n <= (cnt_nx != '0);
      ae_n    <= (cnt_nx > ae_ofs);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n) |=> (bin_q == $past(bin_q))); // R7
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1); // R11
  AST_RCOUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wptr_s - bin_q} <= DEPTH_X)); // R11
endmodule

// File: rtl/fifo9_dc.sv
module fifo9_dc #(
  parameter int DW    = 9,
  parameter int DEPTH = 16
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            wr_data,
  input  logic                     wr_en1_n,
  input  logic                     wr_en2_cfg,
  input  logic                     rd_en1_n,
  input  logic                     rd_en2_n,
  input  logic [$clog2(DEPTH):0]   ae_offset,
  input  logic [$clog2(DEPTH):0]   af_offset,
  output logic [DW-1:0]            rd_data,
  output logic                     empty_n,
  output logic                     almost_empty_n,
  output logic                     full_n,
  output logic                     almost_full_n
);
  localparam int AW = $clog2(DEPTH);

  logic          wrst_n, rrst_n, wcfg_win, rcfg_win_unused;
  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wptr_in_r, rptr_in_w;
  logic [DW-1:0] mem [DEPTH];

  fifo9_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .srst_n(wrst_n), .cfg_win(wcfg_win));
  fifo9_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .srst_n(rrst_n), .cfg_win(rcfg_win_unused));

  fifo9_ptr_sync #(.W(AW+1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .gray_in(wgray), .bin_out(wptr_in_r));
  fifo9_ptr_sync #(.W(AW+1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .gray_in(rgray), .bin_out(rptr_in_w));

  fifo9_wr_ctl #(.AW(AW)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .cfg_win(wcfg_win),
    .en1_n(wr_en1_n), .en2_cfg(wr_en2_cfg),
    .rptr_s(rptr_in_w), .af_ofs(af_offset),
    .fire(wr_fire), .addr(waddr), .gray(wgray),
    .full_n(full_n), .af_n(almost_full_n));

  fifo9_rd_ctl #(.AW(AW)) u_rd (
    .clk(rclk), .rst_n(rrst_n),
    .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .wptr_s(wptr_in_r), .ae_ofs(ae_offset),
    .fire(rd_fire), .addr(raddr), .gray(rgray),
    .empty_n(empty_n), .ae_n(almost_empty_n));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)      rd_data <= '0;
    else if (rd_fire) rd_data <= mem[raddr];
  end

  AST_DOUT_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!rd_fire) |=> $stable(rd_data)); // R7
endmodule

// File: tb/fifo9_dc_test.sv
module fifo9_dc_test;
  localparam int D = 16;

  logic       wclk = 0, rclk = 0, rst_n = 0;
  logic [8:0] wr_data = '0;
  logic       wr_en1_n = 1, wr_en2_cfg = 1, rd_en1_n = 1, rd_en2_n = 1;
  logic [4:0] ae_offset = 5'd2, af_offset = 5'd3;
  logic [8:0] rd_data;
  logic       empty_n, almost_empty_n, full_n, almost_full_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [8:0] mq[$];
  logic [8:0] last;

  fifo9_dc uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en1_n(wr_en1_n), .wr_en2_cfg(wr_en2_cfg),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .ae_offset(ae_offset), .af_offset(af_offset), .rd_data(rd_data),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .full_n(full_n), .almost_full_n(almost_full_n));

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic flags(input string tag);
    int c = mq.size();
    chk({tag, " R8 empty_n"}, 32'(empty_n), 32'(c != 0));
    chk({tag, " R8 almost_empty_n"}, 32'(almost_empty_n), 32'(c > int'(ae_offset)));
    chk({tag, " R9 full_n"}, 32'(full_n), 32'(c != D));
    chk({tag, " R9 almost_full_n"}, 32'(almost_full_n), 32'(c + int'(af_offset) < D));
  endtask

  task automatic do_reset(input logic pin);
    @(negedge wclk);
    rst_n = 0; wr_en2_cfg = pin;
    repeat (4) @(negedge rclk);
    chk("R1 empty_n in reset", 32'(empty_n), 0);
    chk("R1 rd_data in reset", 32'(rd_data), 0);
    @(negedge wclk) rst_n = 1;
    mq.delete(); last = '0;
    settle();
  endtask

  task automatic do_write(input logic [8:0] d, input logic pin, input logic e1);
    @(negedge wclk);
    wr_data = d; wr_en1_n = e1; wr_en2_cfg = pin;
    @(negedge wclk);
    wr_en1_n = 1;
  endtask

  task automatic do_read(input logic e1, input logic e2);
    @(negedge rclk);
    rd_en1_n = e1; rd_en2_n = e2;
    @(negedge rclk);
    rd_en1_n = 1; rd_en2_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, two-enable mode latched (R2)
    do_reset(1'b1);
    flags("R1 after reset");
    chk("R1 rd_data after reset", 32'(rd_data), 0);

    // R3: non-write enable combinations in two-enable mode
    do_write(9'h055, 1'b0, 1'b0); settle(); flags("R3 en2 low no write");
    do_write(9'h055, 1'b1, 1'b1); settle(); flags("R3 en1 high no write");
    do_write(9'h055, 1'b0, 1'b1); settle(); flags("R3 both inactive no write");
    // R2: pin low after reset still leaves two-enable mode
    wr_en2_cfg = 0; settle();
    do_write(9'h066, 1'b0, 1'b0); settle(); flags("R2 mode kept after reset");

    // R10: first word after write into empty
    do_write(9'h1a5, 1'b1, 1'b0); mq.push_back(9'h1a5);
    for (int i = 0; i < 40 && !empty_n; i++) @(negedge rclk);
    chk("R10 empty_n rose", 32'(empty_n), 1);
    chk("R10 no output before read", 32'(rd_data), 0);
    // R6: partial read enables do nothing
    do_read(1'b0, 1'b1); settle(); flags("R6 only en1");
    chk("R6 only en1 data", 32'(rd_data), 0);
    do_read(1'b1, 1'b0); settle(); flags("R6 only en2");
    do_read(1'b0, 1'b0); last = mq.pop_front();
    chk("R10 first word on read", 32'(rd_data), 32'(last));
    settle(); flags("R10 drained");

    // Sweep offsets, fill past full, drain past empty (R5 R6 R7 R8 R9 R11)
    for (int k = 0; k < 4; k++) begin
      ae_offset = 5'((k * 5) % D);
      af_offset = 5'((k * 6 + 1) % D);
      settle(); flags("R8 offset change");
      for (int i = 0; i <= D; i++) begin
        logic [8:0] w = 9'((k * 37 + i * 11 + 3) & 511);
        do_write(w, 1'b1, 1'b0);
        if (mq.size() < D) mq.push_back(w);
        settle();
        flags(i == D ? "R5 write when full" : "R11 fill step");
      end
      for (int i = 0; i <= D; i++) begin
        do_read(1'b0, 1'b0);
        if (mq.size() > 0) begin
          last = mq.pop_front();
          chk("R6 read order", 32'(rd_data), 32'(last));
        end else begin
          chk("R7 read when empty holds", 32'(rd_data), 32'(last));
        end
        settle();
        flags("R11 drain step");
      end
    end

    // R4: programmable mode, pin level irrelevant
    do_reset(1'b0);
    flags("R1 after reset prog");
    do_write(9'h0f0, 1'b0, 1'b0); mq.push_back(9'h0f0);
    do_write(9'h10f, 1'b1, 1'b0); mq.push_back(9'h10f);
    settle(); flags("R4 two writes");
    do_write(9'h1ff, 1'b1, 1'b1); settle(); flags("R4 en1 high no write");
    do_read(1'b0, 1'b0); chk("R4 word0", 32'(rd_data), 32'(mq.pop_front()));
    do_read(1'b0, 1'b0); chk("R4 word1", 32'(rd_data), 32'(mq.pop_front()));
    settle(); flags("R4 drained");

    // R1: reset while holding data
    do_write(9'h123, 1'b1, 1'b0); settle();
    do_reset(1'b1);
    flags("R1 reset clears");
    chk("R1 rd_data cleared", 32'(rd_data), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule